// File: doc/BRIEF.md
# Interrupt Context Snapshot and Spill Engine

This block saves the interrupted context without holding up entry to the interrupt service routine. When an interrupt is taken, every saved general-purpose register and trap CSR is copied into its own shadow slot in that same clock edge. The core can fetch the routine on the next cycle. The engine then writes the shadow contents into local data memory through a 128-bit write port. It does this in the background while the routine's preamble runs.

The frame is placed below the stack pointer. The engine computes the new stack pointer at capture and presents it to the core. It then writes the frame in ascending address order, one beat of four words at a time, over a valid/ready handshake. A busy flag covers the whole drain. A second interrupt request that arrives while busy is held off until the frame is fully in memory, so the core never takes a nested interrupt with a half-saved context.

The default saved set is 19 words: sixteen integer registers followed by three trap CSRs. A zero pad word brings it to 20 words, which is five beats and an 80-byte frame.

Top module: `ctx_spill_engine`

## Requirements
- R1: While reset is held, `busy_o`, `mem_valid_o` and `frame_done_o` are low.
- R2: On the clock edge where `irq_take_o` is high, all saved words are captured together. Saved word i comes from bits [32i+31:32i] of `regs_i`, and the memory beats carry exactly the values `regs_i` had at that edge.
- R3: `irq_take_o` is high in the same cycle as `irq_req_i` whenever the engine is not busy. The first beat is offered on the cycle after the take.
- R4: The frame base is (`sp_i` − 80) with the low four bits cleared, where `sp_i` is the value at the take edge and the subtraction wraps modulo 2^32. `sp_new_o` shows this base from the cycle after the take until the next take.
- R5: Beat k (k = 0..4) is written to base + 16·k, in ascending order. It carries saved words 4k..4k+3, with word 4k+j in bits [32j+31:32j]. Word 19 is written as zero.
- R6: While `mem_valid_o` is high and `mem_ready_i` is low, the next cycle keeps `mem_valid_o` high with unchanged address and data.
- R7: Changes on `regs_i` after the take edge do not alter the words written for that frame.
- R8: `busy_o` is high from the cycle after the take through the cycle in which the last beat is accepted. `frame_done_o` pulses for one cycle immediately after that acceptance.
- R9: An interrupt request that arrives while busy is not taken. It is taken in the first cycle after the drain completes, provided it is still requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 1 | Interrupt request, held until taken |
| irq_take_o | output | 1 | Interrupt accepted; capture happens on this edge |
| regs_i | input | 608 | Architectural values of the 19 saved words, word i at bits 32i |
| sp_i | input | 32 | Current stack pointer |
| sp_new_o | output | 32 | Stack pointer after frame allocation |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_addr_o | output | 32 | Byte address of the beat, 16-byte aligned |
| mem_data_o | output | 128 | Four saved words of the beat |
| busy_o | output | 1 | Frame drain in progress |
| frame_done_o | output | 1 | One-cycle pulse when the frame is fully stored |

## Verification
The assertions check several properties on every cycle:
- the shadow slots change only on a capture edge, and capture copies the register inputs;
- a beat that is not accepted stays stable;
- the beat index stays in range;
- beat addresses are aligned and rise by 16 after each acceptance;
- busy follows every capture.

Only the bench scenarios can show the rest. The bench randomises the register inputs every cycle and compares each beat against a model taken at the take edge. This shows that each beat's data belongs to the right frame and that words land in the right lanes. The scenarios also exercise stack base arithmetic at unaligned and wrapping stack pointers, the exact cycle at which a held nested request is finally taken, and the done pulse timing under random back-pressure.

// File: rtl/ctx_spill_pkg.sv
// Shared types and helpers for the context spill engine.
// Assumes byte addressing and power-of-two beat sizes.
package ctx_spill_pkg;
    typedef enum logic {DRN_IDLE = 1'b0, DRN_ACTIVE = 1'b1} drain_state_e;

    // Round an address down to a multiple of a power-of-two size.
    function automatic logic [31:0] align_down(input logic [31:0] a, input int unsigned sz);
        return a & ~(32'(sz) - 32'd1);
    endfunction
endpackage

// File: rtl/ctx_shadow.sv
// Shadow slots: one register per saved word, loaded together on capture.
// Slots past NUM_SAVE up to PAD_WORDS are constant zero padding.
// Assumes cap_en is a single-cycle strobe from the take logic.
module ctx_shadow #(
    parameter int XLEN      = 32,
    parameter int NUM_SAVE  = 19,
    parameter int PAD_WORDS = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en,
    input  logic [NUM_SAVE*XLEN-1:0]  regs_i,
    output logic [PAD_WORDS*XLEN-1:0] frame_o
);
    for (genvar g = 0; g < PAD_WORDS; g++) begin : g_slot
        if (g < NUM_SAVE) begin : g_live
            logic [XLEN-1:0] slot_q;
            // Capture this word on the take edge, hold otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n)      slot_q <= '0;
                else if (cap_en) slot_q <= regs_i[g*XLEN +: XLEN];
            end
            assign frame_o[g*XLEN +: XLEN] = slot_q;
        end else begin : g_pad
            assign frame_o[g*XLEN +: XLEN] = '0;
        end
    end

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(frame_o)); // R7
    AST_CAPTURE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> frame_o[NUM_SAVE*XLEN-1:0] == $past(regs_i)); // R2
endmodule

// File: rtl/ctx_frame_addr.sv
// Frame address generator: latches the aligned frame base at capture and
// forms each beat address as base plus beat index times beat size.
// Assumes BEAT_BYTES is a power of two.
module ctx_frame_addr
    import ctx_spill_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int FRAME_BYTES = 80,
    parameter int BEAT_BYTES  = 16,
    parameter int BW          = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [XLEN-1:0] sp_i,
    input  logic [BW-1:0]   beat_idx,
    output logic [XLEN-1:0] base_o,
    output logic [XLEN-1:0] addr_o
);
    logic [XLEN-1:0] base_q;

    // Allocate the frame below the stack pointer on the take edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (cap_en) base_q <= align_down(sp_i - XLEN'(FRAME_BYTES), BEAT_BYTES);
    end

    // Beat address for the current drain position.
    always_comb addr_o = base_q + XLEN'(beat_idx) * XLEN'(BEAT_BYTES);

    assign base_o = base_q;

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[$clog2(BEAT_BYTES)-1:0] == '0); // R4
endmodule

// File: rtl/ctx_drain_seq.sv
// Drain sequencer: walks the beat index from zero to BEATS-1, advancing on
// each accepted beat, and pulses done after the last one.
// Assumes cap_en is never asserted while busy.
module ctx_drain_seq
    import ctx_spill_pkg::*;
#(
    parameter int BEATS = 5,
    parameter int BW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          mem_ready_i,
    output logic          busy_o,
    output logic          valid_o,
    output logic [BW-1:0] beat_o,
    output logic          done_o
);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    drain_state_e  state_q;
    logic [BW-1:0] beat_q;
    logic          done_q;
    logic          accept;

    // A beat moves when offered and the memory is ready.
    always_comb accept = (state_q == DRN_ACTIVE) && mem_ready_i;

    // Sequence state, beat index and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRN_IDLE;
            beat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cap_en) begin
                state_q <= DRN_ACTIVE;
                beat_q  <= '0;
            end else if (accept) begin
                if (beat_q == LAST) begin
                    state_q <= DRN_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    assign busy_o  = (state_q == DRN_ACTIVE);
    assign valid_o = busy_o;
    assign beat_o  = beat_q;
    assign done_o  = done_q;

    AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_q <= LAST); // R5
    AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !mem_ready_i |=> valid_o && $stable(beat_q)); // R6
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> busy_o && beat_q == '0); // R8
endmodule

// File: rtl/ctx_spill_engine.sv
// Top of the interrupt context snapshot and spill engine. Takes an
// interrupt when idle, snapshots the saved words in one edge, allocates a
// stack frame and drains it to memory in the background.
// Assumes irq_req_i is held until irq_take_o is seen.
module ctx_spill_engine #(
    parameter int XLEN     = 32,
    parameter int NUM_SAVE = 19,
    parameter int BUS_W    = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     irq_req_i,
    output logic                     irq_take_o,
    input  logic [NUM_SAVE*XLEN-1:0] regs_i,
    input  logic [XLEN-1:0]          sp_i,
    output logic [XLEN-1:0]          sp_new_o,
    output logic                     mem_valid_o,
    input  logic                     mem_ready_i,
    output logic [XLEN-1:0]          mem_addr_o,
    output logic [BUS_W-1:0]         mem_data_o,
    output logic                     busy_o,
    output logic                     frame_done_o
);
    localparam int WPB         = BUS_W / XLEN;
    localparam int BEATS       = (NUM_SAVE + WPB - 1) / WPB;
    localparam int PAD_WORDS   = BEATS * WPB;
    localparam int BEAT_BYTES  = BUS_W / 8;
    localparam int FRAME_BYTES = PAD_WORDS * XLEN / 8;
    localparam int BW          = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic                      cap_en;
    logic [PAD_WORDS*XLEN-1:0] frame;
    logic [BW-1:0]             beat_idx;

    // Take the interrupt only when no drain is outstanding.
    always_comb cap_en = irq_req_i && !busy_o;
    assign irq_take_o = cap_en;

    ctx_shadow #(.XLEN(XLEN), .NUM_SAVE(NUM_SAVE), .PAD_WORDS(PAD_WORDS)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .regs_i(regs_i), .frame_o(frame)
    );

    ctx_frame_addr #(.XLEN(XLEN), .FRAME_BYTES(FRAME_BYTES), .BEAT_BYTES(BEAT_BYTES), .BW(BW)) u_addr (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .sp_i(sp_i), .beat_idx(beat_idx),
        .base_o(sp_new_o), .addr_o(mem_addr_o)
    );

    ctx_drain_seq #(.BEATS(BEATS), .BW(BW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mem_ready_i(mem_ready_i),
        .busy_o(busy_o), .valid_o(mem_valid_o), .beat_o(beat_idx), .done_o(frame_done_o)
    );

    // Select the four shadow words of the current beat.
    always_comb mem_data_o = frame[beat_idx*BUS_W +: BUS_W];

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && mem_ready_i |=> !mem_valid_o ||
        mem_addr_o == $past(mem_addr_o) + XLEN'(BEAT_BYTES)); // R5
    AST_NO_NESTED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> !irq_take_o); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=> $stable(mem_data_o) && $stable(mem_addr_o)); // R6
endmodule

// File: tb/sim_ctx_spill_engine.sv
`timescale 1ns/100ps
// Bench: behavioural model with beat queues, compared every clock.
module sim_ctx_spill_engine;
    localparam int NS = 19;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         irq_req = 1'b0;
    logic         irq_take;
    logic [NS*32-1:0] regs = '0;
    logic [31:0]  sp = 32'h0;
    logic [31:0]  sp_new;
    logic         mvalid, mready = 1'b1;
    logic [31:0]  maddr;
    logic [127:0] mdata;
    logic         busy, done;

    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  bp_mode = 1'b0;

    logic [31:0]  q_addr[$];
    logic [127:0] q_data[$];
    bit           m_busy = 1'b0, exp_done = 1'b0, have_sp = 1'b0;
    logic [31:0]  exp_sp = '0;

    always #2.5 clk = ~clk;

    ctx_spill_engine u0 (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_take_o(irq_take),
        .regs_i(regs), .sp_i(sp), .sp_new_o(sp_new), .mem_valid_o(mvalid),
        .mem_ready_i(mready), .mem_addr_o(maddr), .mem_data_o(mdata),
        .busy_o(busy), .frame_done_o(done)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Randomise architectural registers and ready on each falling edge.
    always @(negedge clk) begin
        for (int i = 0; i < NS; i++) regs[i*32 +: 32] = $urandom;
        mready = bp_mode ? 1'($urandom % 2) : 1'b1;
    end

    // Reference model: compare, then advance by one clock.
    always @(negedge clk) begin
        #1;
        cyc++;
        if (!rst_n) begin
            if (cyc > 1) begin
                check(busy == 0, "R1 busy", busy, 0);
                check(mvalid == 0, "R1 valid", mvalid, 0);
                check(done == 0, "R1 done", done, 0);
            end
            q_addr.delete(); q_data.delete();
            m_busy = 0; exp_done = 0;
        end else begin
            bit take_exp;
            check(busy == m_busy, "R8 busy", busy, m_busy);
            check(done == exp_done, "R8 done", done, exp_done);
            check(mvalid == (q_addr.size() > 0), "R3 valid", mvalid, q_addr.size() > 0);
            if (mvalid && q_addr.size() > 0) begin
                check(maddr == q_addr[0], "R5 addr", maddr, q_addr[0]);
                check(mdata == q_data[0], "R2 R7 data", mdata, q_data[0]);
            end
            if (have_sp) check(sp_new == exp_sp, "R4 sp_new", sp_new, exp_sp);
            take_exp = irq_req && !m_busy;
            check(irq_take == take_exp, m_busy ? "R9 take" : "R3 take", irq_take, take_exp);
            exp_done = 0;
            if (mvalid && mready && q_addr.size() > 0) begin
                void'(q_addr.pop_front()); void'(q_data.pop_front());
                if (q_addr.size() == 0) begin m_busy = 0; exp_done = 1; end
            end
            if (take_exp) begin
                logic [31:0] base;
                base = (sp - 32'd80) & ~32'hF;
                for (int k = 0; k < 5; k++) begin
                    logic [127:0] d;
                    for (int j = 0; j < 4; j++)
                        d[j*32 +: 32] = (4*k+j < NS) ? regs[(4*k+j)*32 +: 32] : 32'h0;
                    q_addr.push_back(base + 32'(16*k));
                    q_data.push_back(d);
                end
                m_busy = 1; exp_sp = base; have_sp = 1;
            end
        end
    end

    task automatic raise_irq();
        @(negedge clk);
        irq_req = 1'b1;
        forever begin
            #1;
            if (irq_take) break;
            @(negedge clk);
        end
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #2; end while (busy || irq_req);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Plain frame, memory always ready.
        sp = 32'h2000_0100;
        raise_irq();
        wait_idle();
        // Unaligned stack pointer under random back-pressure, nested request mid-drain.
        sp = 32'h0000_1003; bp_mode = 1'b1;
        raise_irq();
        sp = 32'h0000_0FB0;
        repeat (2) @(negedge clk);
        raise_irq();
        wait_idle();
        // Stack pointer that wraps below zero.
        sp = 32'h0000_0040;
        raise_irq();
        wait_idle();
        // Back-to-back frames with held request.
        bp_mode = 1'b0;
        for (int r = 0; r < 3; r++) begin sp = 32'h3000_0000 + 32'(r*4); raise_irq(); end
        wait_idle();
        bp_mode = 1'b1;
        for (int r = 0; r < 4; r++) begin sp = $urandom; raise_irq(); end
        wait_idle();
        check(q_addr.size() == 0, "R8 drained", q_addr.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule